// File: doc/BRIEF.md
# Pulse-Request to Waitrequest Bus Bridge

This block sits between a processor-side requester that issues one-cycle read and write pulses and a memory-mapped bus whose slave stretches each access by holding a waitrequest line high. It turns each pulse into a bus access toward one slave and reports progress back through a 2-bit ready count. The value 3 means busy and 0 means finished. The requester may issue its next access only once the count reads 0.

On the cycle of the pulse, address, write data and command reach the bus directly from the requester's inputs. From the second cycle of the access on, they come from hold registers loaded on that first cycle, so they stay stable however long the slave stalls. Chip select is raised only for addresses inside a fixed window. An access outside the window finishes at once without a bus cycle, and a read there returns zero. A parameter picks the read-return style. In fixed-timing mode, read data is taken in the cycle the stall ends. In strobe mode, it is taken later, when the slave pulses its read-data-valid input.

Top module: `rdycnt_mm_bridge`

## Requirements
- R1: `mm_chipselect` is high only while `mm_read` or `mm_write` is high and `mm_address` lies in the window BASE to BASE+SIZE-1.
- R2: In the cycle of an idle-time request, `mm_read`, `mm_write`, `mm_address` and `mm_writedata` equal the live requester inputs of that same cycle.
- R3: The stall seen by the bridge is chip select AND `mm_waitrequest`. A slave waitrequest while chip select is low does not delay completion, and a stall that lasts one more cycle keeps the ready count at 3 in the next cycle.
- R4: While chip select and `mm_waitrequest` are both high, address, write data, read and write keep their values in the next cycle, even if the requester inputs change.
- R5: `cpu_rdy_cnt` only takes the values 3 (busy) and 0 (done). It reads 3 in the cycle after a request unless that request completed in its own cycle, and it returns to 0 once the access finishes.
- R6: With USE_VALID=0, a read returns the `mm_readdata` value present in the cycle in which the stall ends.
- R7: With USE_VALID=1, a read in range returns the `mm_readdata` value present on the `mm_readdatavalid` strobe, not the value at the end of the stall. A strobe while no read is pending changes nothing.
- R8: An access outside the window completes with ready count 0 in the next cycle, with `cpu_rdata` equal to zero for a read, and it drives no chip select, so slave storage is untouched.
- R9: `cpu_rdata` keeps the last read result until a newer read completes. Writes and idle cycles leave it unchanged.
- R10: Synchronous active-high `rst` sets the ready count to 0, `cpu_rdata` to zero, and drives read, write and chip select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | AW | Requester address, valid with a pulse |
| cpu_wdata | input | DW | Requester write data, valid with a write pulse |
| cpu_rd | input | 1 | One-cycle read request |
| cpu_wr | input | 1 | One-cycle write request |
| cpu_rdata | output | DW | Last read result |
| cpu_rdy_cnt | output | 2 | Ready count: 3 busy, 0 done |
| mm_address | output | AW | Bus address |
| mm_writedata | output | DW | Bus write data |
| mm_read | output | 1 | Bus read command |
| mm_write | output | 1 | Bus write command |
| mm_chipselect | output | 1 | Slave select, window-qualified |
| mm_waitrequest | input | 1 | Slave stall |
| mm_readdata | input | DW | Slave read data |
| mm_readdatavalid | input | 1 | Slave read-data strobe (strobe mode) |

## Verification
The assertions check the following on every cycle: the window qualification of chip select, the pass-through of the live request on its first cycle, the freezing of the bus fields during a stall, the two-value ready count, the immediate zero result of a read outside the window, and the holding of read data while idle. Only the bench scenarios can show other parts of the behaviour. These are that the correct slave word arrives in each read-return mode, that a stray strobe or a slave waitrequest while chip select is low has no effect, and that an outside-window write leaves slave storage untouched. It does this by comparing read results against a shadow copy of the slave contents over mixed stall lengths and read latencies.

// File: rtl/rmb_pkg.sv
package rmb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUS   = 2'd1,
        ST_RDATA = 2'd2
    } rmb_state_e;

    localparam logic [1:0] RDY_BUSY = 2'd3;
    localparam logic [1:0] RDY_DONE = 2'd0;
endpackage

// File: rtl/rmb_range_dec.sv
module rmb_range_dec #(
    parameter int AW = 16,
    parameter int unsigned BASE = 32'h1000,
    parameter int unsigned SIZE = 32'h100
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam logic [AW:0] LO = (AW+1)'(BASE);
    localparam logic [AW:0] HI = (AW+1)'(BASE + SIZE);

    always_comb begin
        hit = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    end
endmodule

// File: rtl/rmb_cmd_hold.sv
module rmb_cmd_hold #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          live_rd,
    input  logic          live_wr,
    input  logic [AW-1:0] live_addr,
    input  logic [DW-1:0] live_wdata,
    output logic          cmd_rd,
    output logic          cmd_wr,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_wdata
);
    typedef struct packed {
        logic          rd;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.rd    = live_rd;
            hold_d.wr    = live_wr;
            hold_d.addr  = live_addr;
            hold_d.wdata = live_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    // first cycle: live inputs; later cycles: held copy
    always_comb begin
        cmd_rd    = load ? live_rd    : hold_q.rd;
        cmd_wr    = load ? live_wr    : hold_q.wr;
        cmd_addr  = load ? live_addr  : hold_q.addr;
        cmd_wdata = load ? live_wdata : hold_q.wdata;
    end
endmodule

// File: rtl/rdycnt_mm_bridge.sv
module rdycnt_mm_bridge
    import rmb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int unsigned BASE = 32'h1000,
    parameter int unsigned SIZE = 32'h100,
    parameter bit USE_VALID = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    output logic [DW-1:0] cpu_rdata,
    output logic [1:0]    cpu_rdy_cnt,
    output logic [AW-1:0] mm_address,
    output logic [DW-1:0] mm_writedata,
    output logic          mm_read,
    output logic          mm_write,
    output logic          mm_chipselect,
    input  logic          mm_waitrequest,
    input  logic [DW-1:0] mm_readdata,
    input  logic          mm_readdatavalid
);
    typedef struct packed {
        rmb_state_e    st;
        logic [1:0]    rdy;
        logic [DW-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic          start;
    logic          active;
    logic          cmd_rd, cmd_wr;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;
    logic          in_win;
    logic          stall;
    logic          strobe;

    always_comb begin
        start  = (r_q.st == ST_IDLE) && (cpu_rd || cpu_wr);
        active = start || (r_q.st == ST_BUS);
    end

    rmb_cmd_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .load       (start),
        .live_rd    (cpu_rd),
        .live_wr    (cpu_wr),
        .live_addr  (cpu_addr),
        .live_wdata (cpu_wdata),
        .cmd_rd     (cmd_rd),
        .cmd_wr     (cmd_wr),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata)
    );

    rmb_range_dec #(.AW(AW), .BASE(BASE), .SIZE(SIZE)) u_dec (
        .addr (cmd_addr),
        .hit  (in_win)
    );

    generate
        if (USE_VALID) begin : g_strobe
            assign strobe = mm_readdatavalid;
        end else begin : g_fixed
            assign strobe = 1'b0;
        end
    endgenerate

    always_comb begin
        mm_read       = active && cmd_rd;
        mm_write      = active && cmd_wr;
        mm_chipselect = active && in_win && (cmd_rd || cmd_wr);
        mm_address    = cmd_addr;
        mm_writedata  = cmd_wdata;
        stall         = mm_chipselect && mm_waitrequest;
    end

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE, ST_BUS: begin
                if (active) begin
                    if (stall) begin
                        r_d.st  = ST_BUS;
                        r_d.rdy = RDY_BUSY;
                    end else if (USE_VALID && cmd_rd && in_win) begin
                        r_d.st  = ST_RDATA;
                        r_d.rdy = RDY_BUSY;
                    end else begin
                        r_d.st  = ST_IDLE;
                        r_d.rdy = RDY_DONE;
                        if (cmd_rd) r_d.rdata = in_win ? mm_readdata : '0;
                    end
                end
            end
            ST_RDATA: begin
                if (strobe) begin
                    r_d.st    = ST_IDLE;
                    r_d.rdy   = RDY_DONE;
                    r_d.rdata = mm_readdata;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.rdy = RDY_DONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= ST_IDLE;
            r_q.rdy   <= RDY_DONE;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cpu_rdata   = r_q.rdata;
        cpu_rdy_cnt = r_q.rdy;
    end
endmodule

module rmb_bridge_chk #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int unsigned BASE = 32'h1000,
    parameter int unsigned SIZE = 32'h100
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] cpu_addr,
    input logic          cpu_rd,
    input logic          cpu_wr,
    input logic [DW-1:0] cpu_rdata,
    input logic [1:0]    cpu_rdy_cnt,
    input logic [AW-1:0] mm_address,
    input logic [DW-1:0] mm_writedata,
    input logic          mm_read,
    input logic          mm_write,
    input logic          mm_chipselect,
    input logic          mm_waitrequest
);
    localparam logic [AW:0] LO = (AW+1)'(BASE);
    localparam logic [AW:0] HI = (AW+1)'(BASE + SIZE);

    logic bus_in_win, req_in_win;
    always_comb begin
        bus_in_win = ({1'b0, mm_address} >= LO) && ({1'b0, mm_address} < HI);
        req_in_win = ({1'b0, cpu_addr} >= LO) && ({1'b0, cpu_addr} < HI);
    end

    // R1
    cs_window_chk: assert property (@(posedge clk) disable iff (rst)
        mm_chipselect |-> ((mm_read || mm_write) && bus_in_win));

    // R2
    live_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rdy_cnt == 2'd0 && (cpu_rd ^ cpu_wr)) |->
            (mm_read == cpu_rd && mm_write == cpu_wr && mm_address == cpu_addr));

    // R3
    stall_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (mm_chipselect && mm_waitrequest) |=> (cpu_rdy_cnt == 2'd3));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mm_chipselect && mm_waitrequest) |=>
            ($stable(mm_address) && $stable(mm_writedata) &&
             $stable(mm_read) && $stable(mm_write)));

    // R5
    rdy_code_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rdy_cnt == 2'd0) || (cpu_rdy_cnt == 2'd3));

    // R8
    outside_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rdy_cnt == 2'd0 && cpu_rd && !cpu_wr && !req_in_win) |=>
            (cpu_rdy_cnt == 2'd0 && cpu_rdata == '0));

    // R9
    rdata_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rdy_cnt == 2'd0 && !cpu_rd && !cpu_wr) |=> $stable(cpu_rdata));
endmodule

bind rdycnt_mm_bridge rmb_bridge_chk #(
    .AW(AW), .DW(DW), .BASE(BASE), .SIZE(SIZE)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_addr       (cpu_addr),
    .cpu_rd         (cpu_rd),
    .cpu_wr         (cpu_wr),
    .cpu_rdata      (cpu_rdata),
    .cpu_rdy_cnt    (cpu_rdy_cnt),
    .mm_address     (mm_address),
    .mm_writedata   (mm_writedata),
    .mm_read        (mm_read),
    .mm_write       (mm_write),
    .mm_chipselect  (mm_chipselect),
    .mm_waitrequest (mm_waitrequest)
);

// File: tb/rdycnt_mm_bridge_bench.sv
module rmb_slave_model #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter bit USE_VALID = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [3:0]    wait_n,
    input  logic [3:0]    lat_n,
    output logic          waitreq,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [DW-1:0] mem [16];
    logic [3:0]    wcnt, pcnt, paddr;
    logic          pend, rv_q, acc;
    logic [DW-1:0] rd_q;

    always_comb begin
        waitreq = (wcnt < wait_n);
        acc     = cs && (rd || wr) && !waitreq;
        rvalid  = USE_VALID ? rv_q : 1'b0;
        if (USE_VALID) rdata = rv_q ? rd_q : 32'hDEAD_BEEF;
        else           rdata = (acc && rd) ? mem[addr[3:0]] : 32'hDEAD_BEEF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'hA500_0000 + DW'(i);
            wcnt <= '0; pcnt <= '0; paddr <= '0; pend <= 1'b0;
            rv_q <= 1'b0; rd_q <= '0;
        end else begin
            rv_q <= 1'b0;
            if (cs && (rd || wr) && waitreq) wcnt <= wcnt + 4'd1;
            if (acc) begin
                wcnt <= '0;
                if (wr) mem[addr[3:0]] <= wdata;
                if (rd && USE_VALID) begin
                    pend <= 1'b1; pcnt <= lat_n; paddr <= addr[3:0];
                end
            end else if (pend) begin
                if (pcnt == 4'd0) begin
                    rv_q <= 1'b1; rd_q <= mem[paddr]; pend <= 1'b0;
                end else begin
                    pcnt <= pcnt - 4'd1;
                end
            end
        end
    end
endmodule

module rdycnt_mm_bridge_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int unsigned BASE = 32'h1000;
    localparam int unsigned SIZE = 32'h100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [3:0] wait_n = '0, lat_n = '0;
    logic stray = 1'b0;

    // strobe-mode instance
    logic [DW-1:0] v_rdata, v_wd, v_srd;
    logic [1:0]    v_cnt;
    logic [AW-1:0] v_addr;
    logic v_rd, v_wr, v_cs, v_wait, v_rv;
    // fixed-timing instance
    logic [DW-1:0] f_rdata, f_wd, f_srd;
    logic [1:0]    f_cnt;
    logic [AW-1:0] f_addr;
    logic f_rd, f_wr, f_cs, f_wait, f_rv;

    rdycnt_mm_bridge #(.AW(AW), .DW(DW), .BASE(BASE), .SIZE(SIZE), .USE_VALID(1'b1)) u_rdycnt_mm_bridge (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(v_rdata), .cpu_rdy_cnt(v_cnt),
        .mm_address(v_addr), .mm_writedata(v_wd), .mm_read(v_rd), .mm_write(v_wr),
        .mm_chipselect(v_cs), .mm_waitrequest(v_wait), .mm_readdata(v_srd),
        .mm_readdatavalid(v_rv | stray));

    rmb_slave_model #(.AW(AW), .DW(DW), .USE_VALID(1'b1)) u_slave_v (
        .clk(clk), .rst(rst), .cs(v_cs), .rd(v_rd), .wr(v_wr), .addr(v_addr),
        .wdata(v_wd), .wait_n(wait_n), .lat_n(lat_n), .waitreq(v_wait),
        .rdata(v_srd), .rvalid(v_rv));

    rdycnt_mm_bridge #(.AW(AW), .DW(DW), .BASE(BASE), .SIZE(SIZE), .USE_VALID(1'b0)) u_rdycnt_mm_bridge_fixed (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(f_rdata), .cpu_rdy_cnt(f_cnt),
        .mm_address(f_addr), .mm_writedata(f_wd), .mm_read(f_rd), .mm_write(f_wr),
        .mm_chipselect(f_cs), .mm_waitrequest(f_wait), .mm_readdata(f_srd),
        .mm_readdatavalid(f_rv));

    rmb_slave_model #(.AW(AW), .DW(DW), .USE_VALID(1'b0)) u_slave_f (
        .clk(clk), .rst(rst), .cs(f_cs), .rd(f_rd), .wr(f_wr), .addr(f_addr),
        .wdata(f_wd), .wait_n(wait_n), .lat_n(lat_n), .waitreq(f_wait),
        .rdata(f_srd), .rvalid(f_rv));

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] shadow [16];
    logic [DW-1:0] exp_rd;

    function automatic bit in_win(input logic [AW-1:0] a);
        return (32'(a) >= BASE) && (32'(a) < BASE + SIZE);
    endfunction

    function automatic bit quick_done(input bit is_rd, input bit inw,
                                      input logic [3:0] wn, input bit strobe_mode);
        return !inw || (wn == 4'd0 && (!is_rd || !strobe_mode));
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_req(input bit is_rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [3:0] wn, input logic [3:0] ln);
        bit inw;
        int guard;
        inw = in_win(a);
        @(negedge clk);
        wait_n = wn; lat_n = ln;
        cpu_addr = a; cpu_wdata = d; cpu_rd = is_rd; cpu_wr = !is_rd;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        cpu_addr = 16'h5A5A; cpu_wdata = 32'h0BAD_F00D;  // R4: inputs change during stall
        check("R5 strobe-mode first count", 32'(v_cnt),
              quick_done(is_rd, inw, wn, 1'b1) ? 32'd0 : 32'd3);
        check("R5 fixed-mode first count", 32'(f_cnt),
              quick_done(is_rd, inw, wn, 1'b0) ? 32'd0 : 32'd3);
        guard = 0;
        while ((v_cnt != 2'd0 || f_cnt != 2'd0) && guard < 64) begin
            @(negedge clk);
            guard++;
        end
        check("R5 count returns to 0", 32'(guard < 64), 32'd1);
        if (is_rd) exp_rd = inw ? shadow[a[3:0]] : '0;          // R8 zero outside
        else if (inw) shadow[a[3:0]] = d;
        check("R7 strobe-mode read data", v_rdata, exp_rd);
        check("R6 fixed-mode read data", f_rdata, exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 16; i++) shadow[i] = 32'hA500_0000 + DW'(i);
        exp_rd = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 count", 32'(v_cnt), 32'd0);
        check("R10 rdata", v_rdata, 32'd0);
        check("R10 bus idle", {29'd0, v_rd, v_wr, v_cs}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        do_req(1'b0, 16'h1003, 32'h1111_2222, 4'd0, 4'd0);  // R3 immediate write
        do_req(1'b1, 16'h1003, '0, 4'd0, 4'd2);             // R6 R7
        do_req(1'b0, 16'h1005, 32'h3333_4444, 4'd3, 4'd0);  // R4 stalled write
        do_req(1'b1, 16'h1005, '0, 4'd2, 4'd3);
        // R9 a write leaves read data
        do_req(1'b0, 16'h1007, 32'h7777_0000, 4'd1, 4'd0);
        check("R9 rdata after write", f_rdata, 32'h3333_4444);
        // R3 R8 outside window with slave waitrequest high
        do_req(1'b1, 16'h2003, '0, 4'd5, 4'd0);
        check("R8 outside read zero", v_rdata, 32'd0);
        do_req(1'b0, 16'h0FF3, 32'hFFFF_FFFF, 4'd5, 4'd0);
        do_req(1'b1, 16'h1003, '0, 4'd0, 4'd0);
        check("R8 storage untouched", f_rdata, 32'h1111_2222);
        // R7 stray strobe while idle
        @(negedge clk); stray = 1'b1;
        @(negedge clk); stray = 1'b0;
        check("R7 stray strobe ignored", v_rdata, 32'h1111_2222);
        // R1 boundaries of the window
        do_req(1'b0, 16'h10FF, 32'hCAFE_0001, 4'd1, 4'd0);
        do_req(1'b1, 16'h10FF, '0, 4'd0, 4'd1);
        do_req(1'b1, 16'h1100, '0, 4'd0, 4'd1);
        check("R1 just past window reads zero", v_rdata, 32'd0);

        for (int n = 0; n < 80; n++) begin
            logic [AW-1:0] a;
            a = ($urandom % 8 == 0) ? 16'h3000 + 16'($urandom % 16)
                                    : 16'(BASE) + 16'($urandom % 16);
            do_req(1'($urandom % 2), a, $urandom, 4'($urandom % 4), 4'($urandom % 4));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule